// File: doc/BRIEF.md
# I2C Client Bus Timeout Monitor

This block sits beside the protocol engine of an I2C client and watches the already synchronized SCL line together with the START, STOP and address-match indications that the engine produces. It enforces two independent watchdogs. The first one catches SCL stuck low for one long stretch. The second one adds up every SCL-low interval inside one transaction, from START to STOP, and catches a transaction whose total low time grows too large.

Both watchdogs measure time in ticks from an internal prescaler, nominally one tick per millisecond. When either watchdog expires, the block raises a one-cycle pulse that resets the engine's protocol state machine. In the same cycle it raises a release pulse, but only if the engine is stretching the clock at that moment. The block has no path to the interrupt flags, so flags that are already pending stay set. If a timeout cuts off a transaction whose address matched, the block asks for the stop-received flag when the STOP finally arrives. This replaces the flag that the reset engine can no longer raise.

Top module: `i2c_tmo_monitor`

## Requirements
- R1: With `low_tmo_en_i`=1, SCL held low (`scl_i`=0) for LOW_TICKS consecutive ticks gives one cycle of `fsm_reset_o`=1. This happens in the cycle after the tick that completes the count. Any cycle with `scl_i`=1 clears the continuous count.
- R2: With `ext_tmo_en_i`=1 and a transaction open, ticks during which SCL is low are summed across all of its low phases. When the sum reaches EXT_TICKS, `fsm_reset_o` pulses for one cycle. A transaction is open after a `start_det_i` cycle and until a `stop_det_i` cycle.
- R3: `hold_release_o` is 1 exactly in the cycles where `fsm_reset_o` is 1 and `hold_active_i` is 1.
- R4: Each counter saturates at its limit. SCL stuck low gives one continuous timeout in total. The continuous watchdog rearms only after SCL returns high. The cumulative watchdog rearms only on START or STOP.
- R5: A watchdog whose enable is 0 produces no pulse, and its count is held at zero.
- R6: A STOP arriving while a transaction is open gives one cycle of `stop_flag_req_o`=1 in the next cycle, provided both of these happened earlier in that transaction: `addr_match_i` was seen, and a timeout pulse occurred. A STOP in any other case leaves `stop_flag_req_o` at 0.
- R7: START and STOP clear the cumulative sum. SCL-low ticks outside an open transaction are not summed.
- R8: A tick occurs every CLK_PER_TICK clock cycles. The first tick falls in cycle CLK_PER_TICK-1, where cycle 0 is the first active edge after reset.
- R9: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_tmo_en_i | input | 1 | Enables the continuous SCL-low watchdog |
| ext_tmo_en_i | input | 1 | Enables the cumulative per-transaction watchdog |
| scl_i | input | 1 | SCL, already synchronized to clk |
| start_det_i | input | 1 | One-cycle START (or repeated START) indication |
| stop_det_i | input | 1 | One-cycle STOP indication |
| addr_match_i | input | 1 | One-cycle own-address-recognized indication |
| hold_active_i | input | 1 | The engine is currently stretching SCL |
| hold_release_o | output | 1 | Pulse: drop the clock stretch |
| fsm_reset_o | output | 1 | Pulse: reset the protocol state machine |
| stop_flag_req_o | output | 1 | Pulse: raise the stop-received flag |

## Verification
The properties assume that `scl_i` is already free of metastability. They also assume that START and STOP indications last one cycle each, and that the prescaler divides by at least two, so that two timeout pulses can never fall on adjacent cycles. The stimulus only changes inputs away from the clock edge. It never asserts START and STOP in the same cycle, and it keeps SCL low phases several ticks long. The reference model therefore sees the same event order as the design, and each scenario isolates one watchdog at a time.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  localparam int TMO_CW = 8;  // counters hold limits up to 255 ticks
  typedef logic [TMO_CW-1:0] tmo_cnt_t;

  // Next value of a saturating tick counter.
  function automatic tmo_cnt_t tmo_step(tmo_cnt_t cnt, int limit, logic clr, logic adv);
    if (clr) return '0;
    if (adv && (cnt != tmo_cnt_t'(limit))) return cnt + tmo_cnt_t'(1);
    return cnt;
  endfunction

  // True when this advance lands exactly on the limit.
  function automatic logic tmo_hits(tmo_cnt_t cnt, int limit, logic adv);
    return adv && (cnt == tmo_cnt_t'(limit - 1));
  endfunction
endpackage

// File: rtl/tmo_tick_gen.sv
module tmo_tick_gen #(
  parameter int CLK_PER_TICK = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_TICK - 1);

  logic [TW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + TW'(1);
  end
endmodule

// File: rtl/tmo_low_timer.sv
module tmo_low_timer
  import i2c_tmo_pkg::*;
#(
  parameter int LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_i,
  input  logic tick_i,
  output logic evt_o
);
  tmo_cnt_t run_q;
  logic     clr, adv, hit;

  assign clr = ~en_i | scl_i;
  assign adv = en_i & ~scl_i & tick_i;
  assign hit = tmo_hits(run_q, LIMIT, adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      evt_o <= 1'b0;
    end else begin
      run_q <= tmo_step(run_q, LIMIT, clr, adv);
      evt_o <= hit;
    end
  end
endmodule

// File: rtl/tmo_ext_timer.sv
module tmo_ext_timer
  import i2c_tmo_pkg::*;
#(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic scl_i,
  input  logic tick_i,
  input  logic xfer_i,
  input  logic start_i,
  input  logic stop_i,
  output logic evt_o
);
  tmo_cnt_t sum_q;
  logic     clr, adv, hit;

  assign clr = ~en_i | start_i | stop_i;
  assign adv = en_i & xfer_i & ~scl_i & tick_i & ~start_i & ~stop_i;
  assign hit = tmo_hits(sum_q, LIMIT, adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      evt_o <= 1'b0;
    end else begin
      sum_q <= tmo_step(sum_q, LIMIT, clr, adv);
      evt_o <= hit;
    end
  end
endmodule

// File: rtl/i2c_tmo_monitor.sv
module i2c_tmo_monitor #(
  parameter int CLK_PER_TICK = 200000,
  parameter int LOW_TICKS    = 30,
  parameter int EXT_TICKS    = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_tmo_en_i,
  input  logic ext_tmo_en_i,
  input  logic scl_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic addr_match_i,
  input  logic hold_active_i,
  output logic hold_release_o,
  output logic fsm_reset_o,
  output logic stop_flag_req_o
);
  // Named internal events, brought out for the checker.
  logic tick;
  logic low_evt;
  logic ext_evt;
  logic tmo_pulse;
  logic xfer_q;
  logic addr_seen_q;
  logic tmo_seen_q;
  logic stop_req_q;

  tmo_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  tmo_low_timer #(.LIMIT(LOW_TICKS)) u_low (
    .clk(clk), .rst_n(rst_n), .en_i(low_tmo_en_i), .scl_i(scl_i),
    .tick_i(tick), .evt_o(low_evt)
  );

  tmo_ext_timer #(.LIMIT(EXT_TICKS)) u_ext (
    .clk(clk), .rst_n(rst_n), .en_i(ext_tmo_en_i), .scl_i(scl_i),
    .tick_i(tick), .xfer_i(xfer_q), .start_i(start_det_i),
    .stop_i(stop_det_i), .evt_o(ext_evt)
  );

  assign tmo_pulse = low_evt | ext_evt;

  // Transaction window and the facts remembered about it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_q      <= 1'b0;
      addr_seen_q <= 1'b0;
      tmo_seen_q  <= 1'b0;
      stop_req_q  <= 1'b0;
    end else begin
      stop_req_q <= stop_det_i & xfer_q & addr_seen_q & tmo_seen_q;
      if (start_det_i)     xfer_q <= 1'b1;
      else if (stop_det_i) xfer_q <= 1'b0;
      if (start_det_i | stop_det_i) begin
        addr_seen_q <= 1'b0;
        tmo_seen_q  <= 1'b0;
      end else begin
        addr_seen_q <= addr_seen_q | (addr_match_i & xfer_q);
        tmo_seen_q  <= tmo_seen_q  | (tmo_pulse & xfer_q);
      end
    end
  end

  assign fsm_reset_o     = tmo_pulse;
  assign hold_release_o  = tmo_pulse & hold_active_i;
  assign stop_flag_req_o = stop_req_q;
endmodule

// File: rtl/i2c_tmo_monitor_sva.sv
module i2c_tmo_monitor_sva (
  input logic clk,
  input logic rst_n,
  input logic low_tmo_en_i,
  input logic ext_tmo_en_i,
  input logic scl_i,
  input logic stop_det_i,
  input logic low_evt,
  input logic ext_evt,
  input logic hold_release_o,
  input logic fsm_reset_o,
  input logic stop_flag_req_o
);
  // R1: a high SCL level forbids a continuous timeout on the next cycle
  p_scl_high_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i |=> !low_evt);
  // R3: the release pulse never appears without the reset pulse
  p_release_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_release_o |-> fsm_reset_o);
  // R4: each watchdog event lasts a single cycle
  p_low_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> !low_evt);
  p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> !ext_evt);
  // R5: a disabled watchdog stays silent
  p_low_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !low_tmo_en_i |=> !low_evt);
  p_ext_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_tmo_en_i |=> !ext_evt);
  // R6: a stop-flag request follows a STOP by one cycle
  p_stop_req_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_req_o |-> $past(stop_det_i));
  p_stop_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag_req_o |=> !stop_flag_req_o);
endmodule

bind i2c_tmo_monitor i2c_tmo_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .low_tmo_en_i(low_tmo_en_i),
  .ext_tmo_en_i(ext_tmo_en_i), .scl_i(scl_i), .stop_det_i(stop_det_i),
  .low_evt(low_evt), .ext_evt(ext_evt), .hold_release_o(hold_release_o),
  .fsm_reset_o(fsm_reset_o), .stop_flag_req_o(stop_flag_req_o)
);

// File: tb/i2c_tmo_monitor_bench.sv
module i2c_tmo_monitor_bench;
  localparam int DIV  = 4;
  localparam int LOWT = 30;
  localparam int EXTT = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low_en = 1'b0, ext_en = 1'b0, scl = 1'b1;
  logic start = 1'b0, stop = 1'b0, am = 1'b0, hold = 1'b0;
  logic rel, rstp, sreq;

  always #2.5 clk = ~clk;

  i2c_tmo_monitor #(.CLK_PER_TICK(DIV), .LOW_TICKS(LOWT), .EXT_TICKS(EXTT)) u_i2c_tmo_monitor (
    .clk(clk), .rst_n(rst_n), .low_tmo_en_i(low_en), .ext_tmo_en_i(ext_en),
    .scl_i(scl), .start_det_i(start), .stop_det_i(stop), .addr_match_i(am),
    .hold_active_i(hold), .hold_release_o(rel), .fsm_reset_o(rstp),
    .stop_flag_req_o(sreq)
  );

  int checks = 0, fails = 0;
  int pulses = 0, reqs = 0;

  // Behavioural reference state
  int  m_cyc, m_low, m_sum;
  bit  m_open, m_addr, m_tmo, m_prev_any;
  bit  e_rst, e_rel, e_req;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Predict the outputs produced by the coming edge, then sample after it.
  task automatic step(string tag);
    bit tk, lo_hit, ex_hit, nreq;
    tk = ((m_cyc % DIV) == DIV - 1);
    m_cyc++;
    lo_hit = 0;
    if (!low_en || scl) m_low = 0;
    else if (tk && m_low < LOWT) begin
      m_low++;
      lo_hit = (m_low == LOWT);
    end
    ex_hit = 0;
    if (!ext_en || start || stop) m_sum = 0;
    else if (m_open && !scl && tk && m_sum < EXTT) begin
      m_sum++;
      ex_hit = (m_sum == EXTT);
    end
    nreq = stop && m_open && m_addr && m_tmo;
    if (start || stop) begin
      m_addr = 0; m_tmo = 0;
    end else begin
      if (am && m_open) m_addr = 1;
      if (m_prev_any && m_open) m_tmo = 1;
    end
    if (start) m_open = 1;
    else if (stop) m_open = 0;
    e_rst = lo_hit || ex_hit;
    e_rel = e_rst && hold;
    e_req = nreq;
    m_prev_any = e_rst;
    @(posedge clk);
    @(negedge clk);
    check(tag, "fsm_reset_o", int'(rstp), int'(e_rst));
    check(tag, "hold_release_o", int'(rel), int'(e_rel));
    check(tag, "stop_flag_req_o", int'(sreq), int'(e_req));
    if (rstp) pulses++;
    if (sreq) reqs++;
    start = 0; stop = 0; am = 0;
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_cyc = 0; m_low = 0; m_sum = 0;
    m_open = 0; m_addr = 0; m_tmo = 0; m_prev_any = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "fsm_reset_o in reset", int'(rstp), 0);
    check("R9", "hold_release_o in reset", int'(rel), 0);
    check("R9", "stop_flag_req_o in reset", int'(sreq), 0);
    rst_n = 1'b1;

    // R1/R8: continuous low with timing checked per cycle; R4: stuck low fires once
    low_en = 1; hold = 1; scl = 0; pulses = 0;
    run("R1", 4 * DIV * LOWT);
    check("R4", "pulses while stuck low", pulses, 1);
    // R1: short low phases separated by high never reach the limit
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      scl = 1; run("R1", 3);
      scl = 0; run("R1", DIV * (LOWT - 2));
    end
    check("R1", "interrupted low pulses", pulses, 0);
    // R4: rearm after high, and R3 with no clock stretch
    scl = 1; run("R4", 2);
    hold = 0; scl = 0; pulses = 0;
    run("R3", DIV * LOWT + 8);
    check("R4", "rearmed continuous pulse", pulses, 1);

    // R5: both watchdogs disabled
    scl = 1; run("R5", 2);
    low_en = 0; ext_en = 0; pulses = 0;
    start = 1; step("R5");
    scl = 0; run("R5", 3 * DIV * LOWT);
    check("R5", "pulses while disabled", pulses, 0);
    scl = 1; stop = 1; step("R5");

    // R2/R6: cumulative timeout inside a matched transaction
    low_en = 1; ext_en = 1; hold = 1; pulses = 0; reqs = 0;
    start = 1; step("R2");
    am = 1; step("R6");
    for (int k = 0; k < 10; k++) begin
      scl = 0; run("R2", 5 * DIV);
      scl = 1; run("R2", 3);
    end
    check("R2", "cumulative pulses", pulses, 1);
    stop = 1; step("R6");
    run("R6", 2);
    check("R6", "stop flag requests", reqs, 1);

    // R7: low time outside a transaction is not summed; START clears the sum
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      scl = 0; run("R7", 5 * DIV);
      scl = 1; run("R7", 3);
    end
    check("R7", "pulses outside transaction", pulses, 0);
    start = 1; step("R7");
    for (int k = 0; k < 4; k++) begin
      scl = 0; run("R7", 5 * DIV); scl = 1; run("R7", 3);
    end
    start = 1; step("R7");
    for (int k = 0; k < 4; k++) begin
      scl = 0; run("R7", 5 * DIV); scl = 1; run("R7", 3);
    end
    check("R7", "pulses after restart", pulses, 0);
    // R6: STOP without a timeout raises no request
    reqs = 0; stop = 1; step("R6");
    run("R6", 2);
    check("R6", "request without timeout", reqs, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule